// File: doc/BRIEF.md
# Bit-Field Extract and Insert Unit

This unit performs field operations on a data word, given a field start position and a field length. It can pull a field out of a source word and return it right-justified, with either zero fill or sign fill above it. It can also merge the low bits of a source word into a chosen field of a destination word and leave every other bit of the destination untouched. It sits beside an execution datapath. Register file access and instruction decoding are outside it.

The caller presents the operands and the operation code together with a one-cycle valid strobe. The result and an illegal-field flag appear on registered outputs one clock later. They keep their values until the next strobe. A field that does not fit inside the word is rejected: the unit raises the flag and returns zero.

Top module: `bitfield_unit`

## Requirements
- R1: With op code 0 (unsigned extract), the result holds bits pos through pos+len-1 of src_a in its bits 0 through len-1, and every bit above them is zero.
- R2: With op code 1 (signed extract), the low len bits of the result match R1, and every bit above them equals bit pos+len-1 of src_a.
- R3: With op code 2 (insert), bits pos through pos+len-1 of the result equal bits 0 through len-1 of src_a, and every other result bit equals the same bit of dst_t.
- R4: For op codes 0 to 2, a field with len equal to 0 or with pos+len greater than WIDTH is illegal. The unit sets bad_field to 1 and returns a result of zero.
- R5: With pos 0 and len equal to WIDTH, both extract codes return src_a unchanged, and insert returns src_a no matter what dst_t holds.
- R6: out_valid is high in exactly the cycle after a cycle with in_valid high. result and bad_field change only in that cycle and hold their values while in_valid stays low.
- R7: While rst_n is low, out_valid, bad_field and result are all zero.
- R8: Op code 3 is reserved. It gives a result of zero with bad_field at 0, whatever the field values are.
- R9: The extract codes ignore dst_t.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand strobe |
| op | input | 2 | 0 unsigned extract, 1 signed extract, 2 insert, 3 reserved |
| src_a | input | WIDTH | Source word |
| dst_t | input | WIDTH | Destination word, read by insert only |
| pos | input | log2(WIDTH) | Field start bit |
| len | input | log2(WIDTH+1) | Field length in bits |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| result | output | WIDTH | Registered result |
| bad_field | output | 1 | Registered illegal-field flag |

## Verification
Every path in the unit is combinational into a single output register, so any fault shows up at the ports in the cycle right after the strobe. A wrong mask boundary shows up as stray bits just above or below the field. A wrong sign-bit pick shows up as wrong fill in the upper bits, and only on fields whose top bit differs from the bit next to it. A faulty legality check shows up in bad_field on the edge cases pos+len = WIDTH and pos+len = WIDTH+1. A faulty hold or strobe path shows up as a changed result or an extra out_valid during idle cycles.

// File: rtl/bitfield_pkg.sv
package bitfield_pkg;
   typedef enum logic [1:0] {
      BF_EXT_U  = 2'd0,
      BF_EXT_S  = 2'd1,
      BF_INSERT = 2'd2,
      BF_RSVD   = 2'd3
   } bf_op_e;
endpackage

// File: rtl/bf_len_mask.sv
// Thermometer mask: bit i is set when i < len.
module bf_len_mask #(
   parameter int WIDTH = 32,
   parameter int LEN_W = $clog2(WIDTH + 1)
) (
   input  logic [LEN_W-1:0] len,
   output logic [WIDTH-1:0] mask
);
   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign mask[i] = (LEN_W'(i) < len);
   end
endmodule

// File: rtl/bf_extract.sv
// Right-justifies a field and fills the upper bits with zero or the field's top bit.
module bf_extract #(
   parameter int WIDTH = 32,
   parameter int POS_W = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] word,
   input  logic [POS_W-1:0] pos,
   input  logic [WIDTH-1:0] mask,
   input  logic             sign_en,
   output logic [WIDTH-1:0] field
);
   logic [WIDTH-1:0] shifted;
   logic [WIDTH-1:0] top_onehot;
   logic             top_bit;

   assign shifted    = word >> pos;
   assign top_onehot = mask & ~(mask >> 1);
   assign top_bit    = |(shifted & top_onehot);
   assign field      = (shifted & mask) | ((sign_en && top_bit) ? ~mask : '0);
endmodule

// File: rtl/bf_insert.sv
// Merges the low bits of src into the positioned field of dst.
module bf_insert #(
   parameter int WIDTH = 32,
   parameter int POS_W = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] src,
   input  logic [WIDTH-1:0] dst,
   input  logic [POS_W-1:0] pos,
   input  logic [WIDTH-1:0] mask,
   output logic [WIDTH-1:0] merged
);
   logic [WIDTH-1:0] place_mask;

   assign place_mask = mask << pos;
   assign merged     = (dst & ~place_mask) | ((src << pos) & place_mask);
endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit #(
   parameter int WIDTH = 32,
   localparam int POS_W = $clog2(WIDTH),
   localparam int LEN_W = $clog2(WIDTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [1:0]       op,
   input  logic [WIDTH-1:0] src_a,
   input  logic [WIDTH-1:0] dst_t,
   input  logic [POS_W-1:0] pos,
   input  logic [LEN_W-1:0] len,
   output logic             out_valid,
   output logic [WIDTH-1:0] result,
   output logic             bad_field
);
   import bitfield_pkg::*;

   localparam int SUM_W = LEN_W + 1;

   if (WIDTH < 2) begin : g_width_too_small
      $error("bitfield_unit: WIDTH must be at least 2");
   end
   if ((1 << POS_W) != WIDTH) begin : g_width_not_pow2
      $error("bitfield_unit: WIDTH must be a power of two");
   end

   bf_op_e           op_e;
   logic [WIDTH-1:0] len_mask;
   logic [WIDTH-1:0] ext_val;
   logic [WIDTH-1:0] ins_val;
   logic [SUM_W-1:0] field_end;
   logic             legal;
   logic [WIDTH-1:0] next_result;
   logic             next_bad;

   assign op_e      = bf_op_e'(op);
   assign field_end = SUM_W'(pos) + SUM_W'(len);
   assign legal     = (len != '0) && (field_end <= SUM_W'(WIDTH));

   bf_len_mask #(.WIDTH(WIDTH), .LEN_W(LEN_W)) u_mask (
      .len  (len),
      .mask (len_mask)
   );

   bf_extract #(.WIDTH(WIDTH), .POS_W(POS_W)) u_ext (
      .word    (src_a),
      .pos     (pos),
      .mask    (len_mask),
      .sign_en (op_e == BF_EXT_S),
      .field   (ext_val)
   );

   bf_insert #(.WIDTH(WIDTH), .POS_W(POS_W)) u_ins (
      .src    (src_a),
      .dst    (dst_t),
      .pos    (pos),
      .mask   (len_mask),
      .merged (ins_val)
   );

   always_comb begin
      next_result = '0;
      next_bad    = 1'b0;
      case (op_e)
         BF_EXT_U, BF_EXT_S: begin
            next_bad    = !legal;
            next_result = legal ? ext_val : '0;
         end
         BF_INSERT: begin
            next_bad    = !legal;
            next_result = legal ? ins_val : '0;
         end
         default: begin
            next_bad    = 1'b0;
            next_result = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
         bad_field <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            result    <= next_result;
            bad_field <= next_bad;
         end
      end
   end
endmodule

// File: rtl/bitfield_unit_chk.sv
module bitfield_unit_chk #(
   parameter int WIDTH = 32,
   localparam int POS_W = $clog2(WIDTH),
   localparam int LEN_W = $clog2(WIDTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [1:0]       op,
   input logic [WIDTH-1:0] src_a,
   input logic [WIDTH-1:0] dst_t,
   input logic [POS_W-1:0] pos,
   input logic [LEN_W-1:0] len,
   input logic             out_valid,
   input logic [WIDTH-1:0] result,
   input logic             bad_field
);
   logic [2*WIDTH-1:0] wide_mask;
   logic [WIDTH-1:0]   fld_mask;
   logic               fits;

   assign wide_mask = (((2*WIDTH)'(1) << len) - (2*WIDTH)'(1)) << pos;
   assign fld_mask  = wide_mask[WIDTH-1:0];
   assign fits      = (len != '0) && ((int'(pos) + int'(len)) <= WIDTH);

   assert_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   assert_no_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(result) && $stable(bad_field)));
   assert_bad_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      bad_field |-> (result == '0));
   assert_bad_raise_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op != 2'd3 && !fits) |=> bad_field);
   assert_rsvd_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == 2'd3) |=> (!bad_field && result == '0));
   assert_ins_outside_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == 2'd2 && fits) |=>
      (((result ^ $past(dst_t)) & ~$past(fld_mask)) == '0));
   assert_full_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op != 2'd3 && pos == '0 && int'(len) == WIDTH) |=>
      (result == $past(src_a)));
   assert_reset_R7: assert property (@(posedge clk)
      !rst_n |-> (!out_valid && !bad_field && result == '0));
endmodule

bind bitfield_unit bitfield_unit_chk #(.WIDTH(WIDTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .op        (op),
   .src_a     (src_a),
   .dst_t     (dst_t),
   .pos       (pos),
   .len       (len),
   .out_valid (out_valid),
   .result    (result),
   .bad_field (bad_field)
);

// File: tb/sim_bitfield_unit.sv
`timescale 1ns/1ps
module sim_bitfield_unit;
   localparam int W = 32;

   typedef struct packed {
      logic [1:0]  op;
      logic [31:0] a;
      logic [31:0] t;
      logic [4:0]  pos;
      logic [5:0]  len;
      logic [31:0] exp;
      logic        bad;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 19;
   localparam vec_t VEC [NV] = '{
      '{2'd0, 32'hDEADBEEF, 32'h0,        5'd4,  6'd8,  32'h000000EE, 1'b0, 4'd1}, // R1
      '{2'd0, 32'hDEADBEEF, 32'h0,        5'd28, 6'd4,  32'h0000000D, 1'b0, 4'd1}, // R1 field ends at top bit
      '{2'd1, 32'hDEADBEEF, 32'h0,        5'd4,  6'd8,  32'hFFFFFFEE, 1'b0, 4'd2}, // R2 negative field
      '{2'd1, 32'hDEADBEEF, 32'h0,        5'd12, 6'd4,  32'hFFFFFFFB, 1'b0, 4'd2}, // R2
      '{2'd1, 32'h12345678, 32'h0,        5'd8,  6'd8,  32'h00000056, 1'b0, 4'd2}, // R2 positive field
      '{2'd1, 32'h00000001, 32'h0,        5'd0,  6'd1,  32'hFFFFFFFF, 1'b0, 4'd2}, // R2 one-bit field
      '{2'd2, 32'h000000AB, 32'hFFFFFFFF, 5'd8,  6'd8,  32'hFFFFABFF, 1'b0, 4'd3}, // R3
      '{2'd2, 32'hFFFFFFFF, 32'h00000000, 5'd31, 6'd1,  32'h80000000, 1'b0, 4'd3}, // R3 top bit
      '{2'd2, 32'h00000005, 32'h12345678, 5'd4,  6'd3,  32'h12345658, 1'b0, 4'd3}, // R3
      '{2'd0, 32'hDEADBEEF, 32'h0,        5'd30, 6'd3,  32'h00000000, 1'b1, 4'd4}, // R4 overrun by one
      '{2'd2, 32'hFFFFFFFF, 32'h12345678, 5'd0,  6'd0,  32'h00000000, 1'b1, 4'd4}, // R4 zero length
      '{2'd1, 32'hFFFFFFFF, 32'h0,        5'd0,  6'd40, 32'h00000000, 1'b1, 4'd4}, // R4 length too large
      '{2'd2, 32'hFFFFFFFF, 32'hFFFFFFFF, 5'd1,  6'd32, 32'h00000000, 1'b1, 4'd4}, // R4
      '{2'd0, 32'h89ABCDEF, 32'h0,        5'd0,  6'd32, 32'h89ABCDEF, 1'b0, 4'd5}, // R5
      '{2'd1, 32'h89ABCDEF, 32'h0,        5'd0,  6'd32, 32'h89ABCDEF, 1'b0, 4'd5}, // R5
      '{2'd2, 32'h12345678, 32'hCAFEF00D, 5'd0,  6'd32, 32'h12345678, 1'b0, 4'd5}, // R5
      '{2'd3, 32'hFFFFFFFF, 32'hFFFFFFFF, 5'd4,  6'd8,  32'h00000000, 1'b0, 4'd8}, // R8
      '{2'd3, 32'hFFFFFFFF, 32'h0,        5'd30, 6'd9,  32'h00000000, 1'b0, 4'd8}, // R8 bad field ignored
      '{2'd0, 32'h0000F0F0, 32'hFFFFFFFF, 5'd4,  6'd8,  32'h0000000F, 1'b0, 4'd9}  // R9 dst_t ignored
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [1:0]  op = 2'd0;
   logic [31:0] src_a = '0;
   logic [31:0] dst_t = '0;
   logic [4:0]  pos = '0;
   logic [5:0]  len = '0;
   logic        out_valid;
   logic [31:0] result;
   logic        bad_field;

   int total = 0;
   int bad = 0;

   always #5 clk = ~clk;

   bitfield_unit #(.WIDTH(W)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
      .src_a(src_a), .dst_t(dst_t), .pos(pos), .len(len),
      .out_valid(out_valid), .result(result), .bad_field(bad_field)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic drive(input vec_t v);
      op = v.op; src_a = v.a; dst_t = v.t; pos = v.pos; len = v.len;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      // R7: outputs held at zero during reset
      repeat (2) @(negedge clk);
      check("R7 out_valid", 32'(out_valid), 32'd0);
      check("R7 result", result, 32'd0);
      check("R7 bad_field", 32'(bad_field), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // table walk: strobe, then sample one cycle later
      for (int i = 0; i < NV; i++) begin
         drive(VEC[i]);
         in_valid = 1'b1;
         @(negedge clk);
         in_valid = 1'b0;
         check($sformatf("R%0d vec%0d result", VEC[i].req, i), result, VEC[i].exp);
         check($sformatf("R%0d vec%0d bad_field", VEC[i].req, i), 32'(bad_field), 32'(VEC[i].bad));
         check($sformatf("R6 vec%0d out_valid", i), 32'(out_valid), 32'd1);
      end

      // R6: hold while idle even when the operands change
      drive(VEC[6]);
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      drive(VEC[9]);
      @(negedge clk);
      check("R6 idle out_valid", 32'(out_valid), 32'd0);
      check("R6 idle result hold", result, 32'hFFFFABFF);
      check("R6 idle flag hold", 32'(bad_field), 32'd0);
      @(negedge clk);
      check("R6 idle result hold 2", result, 32'hFFFFABFF);

      // R6: back-to-back strobes, each result one cycle behind its strobe
      drive(VEC[0]);
      in_valid = 1'b1;
      @(negedge clk);
      drive(VEC[2]);
      check("R6 b2b first", result, 32'h000000EE);
      @(negedge clk);
      in_valid = 1'b0;
      check("R6 b2b second", result, 32'hFFFFFFEE);
      check("R6 b2b valid", 32'(out_valid), 32'd1);
      @(negedge clk);
      check("R6 b2b valid drop", 32'(out_valid), 32'd0);

      // R7: reset during operation clears a flagged result
      drive(VEC[10]);
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check("R4 before reset flag", 32'(bad_field), 32'd1);
      rst_n = 1'b0;
      #1;
      check("R7 mid reset flag", 32'(bad_field), 32'd0);
      check("R7 mid reset result", result, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule